// File: doc/BRIEF.md
# APB Subordinate with Registered Read Port

This block is an APB subordinate in front of two kinds of storage: a small register file and a queue window. Both stores use a synchronous read port. The read address is registered, and the data comes out one clock later. Because of this, every read of either store costs exactly one wait state.

In the first ACCESS cycle the block launches the storage read and holds PREADY low. In the second ACCESS cycle it drives the returned word onto PRDATA and raises PREADY in the same cycle. PRDATA carries no meaning during the wait cycle.

A read of the queue data address removes the head entry. The removal happens on the completion edge and never on the wait cycle. A write to that same address appends an entry. Writes and status reads complete with no wait. The status address returns how many entries the queue holds.

Top module: `rdport_apb_sub`

## Requirements
- R1: After reset, PREADY, PSLVERR and PRDATA are low, and the queue reports zero entries.
- R2: A read of a register or of the queue data address shows PREADY low in its first ACCESS cycle. In the second ACCESS cycle it shows PREADY high with the addressed word on PRDATA.
- R3: A write to register index i (byte address 4*i, i below REG_COUNT) is returned by later reads of that address. Other registers are left unchanged.
- R4: Every write completes in its first ACCESS cycle with PREADY high.
- R5: Entries leave the queue in the order they were written to the queue data address (byte 0x40).
- R6: A completed read of the queue data address lowers the count by exactly one. The removal happens on the completion edge only.
- R7: A read of the queue data address while the queue is empty completes after one wait with PSLVERR high and PRDATA zero, and the count is unchanged.
- R8: A write to the queue data address while the queue holds QUEUE_DEPTH entries completes with PSLVERR high and is dropped.
- R9: A read of the status address (byte 0x44) completes in its first ACCESS cycle and returns the entry count in the low bits of PRDATA.
- R10: Back-to-back reads with PSEL held high each insert their own single wait state.
- R11: If PSEL falls before a launched read completes, nothing is removed from the queue, and the next read waits again.
- R12: A read of an unmapped address returns zero after one wait with PSLVERR low. A write to an unmapped address changes no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | ACCESS phase marker |
| pwrite | input | 1 | High for write, low for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, meaningful only when PREADY is high |
| pready | output | 1 | Transfer completion |
| pslverr | output | 1 | Error response at completion |

## Verification
The bench checks the number of waits on every read, so a design that answered in the first ACCESS cycle is caught. Such a design would return the stale word that was latched for the previous read. Queue counts are read back after single reads, after an aborted read and after a full drain. These reads expose a removal on the wait cycle, which would lose an entry, or a removal on an aborted read. Empty reads and over-full writes must both raise the error and leave the count untouched. Reads run back to back with PSEL held high, so a launch flag that never clears would skip the wait on the second read.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic launch;    // latch the storage word for the current read
    logic srcFifo;   // launch source is the queue head
    logic srcReg;    // launch source is the register file
    logic regWr;     // write pwdata into the register file
    logic push;      // append pwdata to the queue
    logic pop;       // retire the queue head
    logic showStat;  // drive the entry count onto prdata
    logic showData;  // drive the latched word onto prdata
  } dpStrobe_t;

endpackage

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
  import rdport_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_COUNT = 4,
  parameter int IDX_W     = 2,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  regIdx,
  output logic              pready,
  output logic              pslverr
);

  localparam int REG_SPAN = REG_COUNT * 4;
  localparam logic [ADDR_W-1:0] REG_LIMIT = ADDR_W'(REG_SPAN);

  logic launchedQ;
  logic isReg, isFifo, isStat;
  logic accessPh, storeRead, readDone, readErr, writeErr;

  assign isReg  = (paddr < REG_LIMIT);
  assign isFifo = (paddr == FIFO_ADDR);
  assign isStat = (paddr == STAT_ADDR);
  assign regIdx = paddr[IDX_W+1:2];

  assign accessPh  = psel && penable;
  assign storeRead = accessPh && !pwrite && !isStat;
  assign readDone  = storeRead && launchedQ;
  assign readErr   = readDone && isFifo && fifoEmpty;
  assign writeErr  = accessPh && pwrite && isFifo && fifoFull;

  always_comb begin
    strobe          = '0;
    strobe.launch   = storeRead && !launchedQ;
    strobe.srcFifo  = isFifo;
    strobe.srcReg   = isReg;
    strobe.regWr    = accessPh && pwrite && isReg;
    strobe.push     = accessPh && pwrite && isFifo && !fifoFull;
    strobe.pop      = readDone && isFifo && !fifoEmpty;
    strobe.showStat = accessPh && !pwrite && isStat;
    strobe.showData = readDone && !readErr;
  end

  assign pready  = accessPh && (pwrite || isStat || launchedQ);
  assign pslverr = readErr || writeErr;

  // Launch flag: set by the launch cycle, cleared at completion or when PSEL drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               launchedQ <= 1'b0;
    else if (!psel)          launchedQ <= 1'b0;
    else if (readDone)       launchedQ <= 1'b0;
    else if (strobe.launch)  launchedQ <= 1'b1;
  end

  AST_FIRST_ACCESS_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(penable) && psel && !pwrite && !isStat) |-> !pready); // R2

  AST_WAIT_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pready) |=> (!psel || pready)); // R10

  AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pwrite) |-> pready); // R4

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (pready && psel && penable)); // R7

endmodule

// File: rtl/rdport_datapath.sv
module rdport_datapath
  import rdport_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REG_COUNT  = 4,
  parameter int IDX_W      = 2,
  parameter int QUEUE_DEPTH = 8,
  parameter int PTR_W      = 3,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] pwdata,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [DATA_W-1:0] prdata
);

  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [DATA_W-1:0] fifoMem [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fillCnt;
  logic [DATA_W-1:0] rdDataQ;

  assign fifoEmpty = (fillCnt == '0);
  assign fifoFull  = (fillCnt == CNT_W'(QUEUE_DEPTH));

  // Register file, one write port per entry
  for (genvar g = 0; g < REG_COUNT; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (strobe.regWr && (regIdx == IDX_W'(g)))
        regFile[g] <= pwdata;
    end
  end

  // Queue storage (no reset on the array)
  always_ff @(posedge clk) begin
    if (strobe.push) fifoMem[wrPtr] <= pwdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  // Synchronous read port: word registered on the launch cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdDataQ <= '0;
    else if (strobe.launch) begin
      if (strobe.srcFifo)     rdDataQ <= fifoMem[rdPtr];
      else if (strobe.srcReg) rdDataQ <= regFile[regIdx];
      else                    rdDataQ <= '0;
    end
  end

  always_comb begin
    if (strobe.showStat)      prdata = {{(DATA_W-CNT_W){1'b0}}, fillCnt};
    else if (strobe.showData) prdata = rdDataQ;
    else                      prdata = '0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(QUEUE_DEPTH)); // R8

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (fillCnt != '0)); // R7

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push) |=> (fillCnt == $past(fillCnt) - 1'b1)); // R6

  AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !strobe.push); // R8

endmodule

// File: rtl/rdport_apb_sub.sv
module rdport_apb_sub
  import rdport_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int REG_COUNT   = 4,
  parameter int QUEUE_DEPTH = 8,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);

  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] regIdx;
  logic             fifoEmpty, fifoFull;

  rdport_ctrl #(
    .ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT), .IDX_W(IDX_W),
    .FIFO_ADDR(FIFO_ADDR), .STAT_ADDR(STAT_ADDR)
  ) ctrl_i (
    .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .strobe(strobe), .regIdx(regIdx),
    .pready(pready), .pslverr(pslverr)
  );

  rdport_datapath #(
    .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .IDX_W(IDX_W),
    .QUEUE_DEPTH(QUEUE_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(pclk), .rstN(presetn), .strobe(strobe), .regIdx(regIdx),
    .pwdata(pwdata), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .prdata(prdata)
  );

endmodule

// File: tb/rdport_apb_sub_tb_top.sv
`timescale 1ns/1ps
module rdport_apb_sub_tb_top;

  localparam logic [7:0] FIFO_A = 8'h40;
  localparam logic [7:0] STAT_A = 8'h44;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;

  always #5 clk = ~clk;

  rdport_apb_sub dut_i (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  typedef struct {
    logic [31:0] data;
    bit          chkData;
    bit          err;
    int          waits;
    string       tag;
  } item_t;

  item_t       sbQ[$];
  logic [31:0] regM [4];
  logic [31:0] fifoM[$];
  int          nCmp = 0;
  int          nBad = 0;
  int          waitCnt = 0;
  bit          done = 0;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // Monitor: compares each completion against the scoreboard head
  always @(negedge clk) begin
    if (rstn && psel && penable) begin
      if (pready) begin
        item_t e;
        nCmp++;
        if (sbQ.size() == 0) begin
          nBad++;
          $display("FAIL unexpected completion: actual data=%h expected none", prdata);
        end else begin
          e = sbQ.pop_front();
          if ((e.chkData && prdata !== e.data) || pslverr !== e.err || waitCnt != e.waits) begin
            nBad++;
            $display("FAIL %s: actual data=%h err=%0b waits=%0d expected data=%h err=%0b waits=%0d",
                     e.tag, prdata, pslverr, waitCnt, e.data, e.err, e.waits);
          end
        end
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1'b1;
    do @(negedge clk); while (!pready);
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle();
    psel = 1'b0; penable = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d, input string tag);
    item_t e;
    e.data = '0; e.chkData = 0; e.err = 0; e.waits = 0; e.tag = tag;
    if (a == FIFO_A) begin
      if (fifoM.size() < DEPTH) fifoM.push_back(d);
      else e.err = 1;
    end else if (a < 8'h10) begin
      regM[a[3:2]] = d;
    end
    sbQ.push_back(e);
    xfer(1'b1, a, d);
  endtask

  task automatic doRead(input logic [7:0] a, input string tag);
    item_t e;
    e.data = '0; e.chkData = 1; e.err = 0; e.waits = 1; e.tag = tag;
    if (a == STAT_A) begin
      e.data = 32'(fifoM.size()); e.waits = 0;
    end else if (a == FIFO_A) begin
      if (fifoM.size() > 0) e.data = fifoM.pop_front();
      else e.err = 1;
    end else if (a < 8'h10) begin
      e.data = regM[a[3:2]];
    end
    sbQ.push_back(e);
    xfer(1'b0, a, 32'h0);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finished run");
    report();
  end

  initial begin
    for (int i = 0; i < 4; i++) regM[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstn = 1'b1;
    @(negedge clk);
    nCmp++;
    if (pready !== 1'b0 || pslverr !== 1'b0 || prdata !== '0) begin
      nBad++;
      $display("FAIL R1 reset outputs: actual rdy=%0b err=%0b data=%h expected 0 0 0",
               pready, pslverr, prdata);
    end
    @(posedge clk); #1;

    doRead(STAT_A, "R1 reset count");
    doRead(8'h08, "R1 reset register");

    // R3/R4: register writes, read back in shuffled order, back to back (R10)
    doWrite(8'h00, 32'hA5A5_0001, "R4 write reg0");
    doWrite(8'h04, 32'h1234_5678, "R4 write reg1");
    doWrite(8'h08, 32'hDEAD_BEEF, "R4 write reg2");
    doWrite(8'h0C, 32'h0F0F_F0F0, "R4 write reg3");
    doRead(8'h08, "R2 R3 read reg2");
    doRead(8'h00, "R10 R3 read reg0");
    doRead(8'h0C, "R10 R3 read reg3");
    doWrite(8'h04, 32'hCAFE_0000, "R3 rewrite reg1");
    doRead(8'h04, "R3 read reg1");
    doRead(8'h00, "R3 reg0 untouched");

    // R7: empty queue read
    doRead(FIFO_A, "R7 empty read");
    doRead(STAT_A, "R7 count after empty read");

    // R5/R6: push three, pop one
    doWrite(FIFO_A, 32'h0000_0011, "R4 push a");
    doWrite(FIFO_A, 32'h0000_0022, "R4 push b");
    doWrite(FIFO_A, 32'h0000_0033, "R4 push c");
    doRead(STAT_A, "R9 count three");
    doRead(FIFO_A, "R5 pop a");
    doRead(STAT_A, "R6 count after one pop");

    // R11: abort a launched queue read
    idle();
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = FIFO_A;
    @(posedge clk); #1 penable = 1'b1;
    @(posedge clk); #1 psel = 1'b0; penable = 1'b0;
    idle();
    doRead(STAT_A, "R11 count after abort");
    doRead(FIFO_A, "R11 R5 pop b after abort");

    // R8: fill to capacity, overflow write, then drain
    for (int i = 0; i < 7; i++) doWrite(FIFO_A, 32'h100 + 32'(i), "R4 fill push");
    doRead(STAT_A, "R9 count full");
    doWrite(FIFO_A, 32'hBAD0_BAD0, "R8 push when full");
    doRead(STAT_A, "R8 count stays full");
    for (int i = 0; i < DEPTH; i++) doRead(FIFO_A, "R5 R6 drain order");
    doRead(STAT_A, "R6 count after drain");
    doRead(FIFO_A, "R7 empty after drain");

    // R12: unmapped addresses
    doWrite(8'h20, 32'hFFFF_FFFF, "R12 unmapped write");
    doRead(8'h20, "R12 unmapped read");
    doRead(8'h04, "R12 reg1 untouched");
    doRead(STAT_A, "R12 count untouched");

    idle();
    repeat (3) @(posedge clk);
    if (sbQ.size() != 0) begin
      nBad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbQ.size());
    end
    report();
  end

endmodule